// File: doc/BRIEF.md
# Multicycle Integer Multiply Unit

This unit multiplies two 32-bit integers for a simple in-order processor's arithmetic stage. The issuing logic raises a one-cycle `start` strobe together with the two operands and a 2-bit opcode. The unit returns a 32-bit word and marks it with a one-cycle `done` pulse.

The parameter `DIGIT_W` picks the datapath. A value of 4 builds a narrow array that takes four multiplier bits per cycle and holds the unit for 11 issue cycles. A value of 16 builds a half-width array that holds the unit for 5 issue cycles. A value of 32 builds a full 32x32 array that can take a new multiply on every cycle. Every variant adds 2 more cycles of result latency after its issue cycles.

The iterative variants (4 and 16) return only the low word of the product, and they raise `busy` while an operation is in flight. The full variant also returns the high word of the 64-bit product under three signedness rules. It never reports busy.

Top module: `mul_unit`

## Requirements
- R1: With opcode 2'b00, `result` equals bits [31:0] of the product of `a` and `b`, whatever the signedness of the operands. This holds in every configuration.
- R2: With `DIGIT_W`=32 and opcode 2'b01, `result` equals bits [63:32] of the product with both `a` and `b` treated as signed.
- R3: With `DIGIT_W`=32 and opcode 2'b10, `result` equals bits [63:32] of the product with `a` treated as signed and `b` treated as unsigned.
- R4: With `DIGIT_W`=32 and opcode 2'b11, `result` equals bits [63:32] of the product with both operands treated as unsigned.
- R5: With `DIGIT_W` below 32, the opcode is ignored and every operation returns the low word of the product.
- R6: Call the cycle in which an accepted `start` is high cycle 0. Then `done` is high in cycle ISSUE+2: cycle 13 for `DIGIT_W`=4, cycle 7 for 16 and cycle 3 for 32. Here ISSUE is 32/`DIGIT_W`+3 for the iterative widths and 1 for 32.
- R7: In the iterative configurations, `done` is high for exactly one cycle. `busy` is high from cycle 1 through the `done` cycle and low at all other times.
- R8: In the iterative configurations, a `start` that arrives while `busy` is high is ignored. It does not change the result or the timing of the operation in flight.
- R9: With `DIGIT_W`=32, `busy` stays low and a `start` is accepted on every cycle. Back-to-back operations each produce their own `done` pulse 3 cycles later, in issue order.
- R10: While `rst` is high, and in the cycle after it, `busy`, `done` and `result` are all zero.
- R11: Outside the `done` cycle and outside `busy`, `result` holds the last completed value, or zero if no operation has completed since reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start strobe, sampled on the rising edge |
| op | input | 2 | Opcode: 00 low word, 01 high signed×signed, 10 high signed×unsigned, 11 high unsigned×unsigned |
| a | input | 32 | Multiplicand |
| b | input | 32 | Multiplier |
| busy | output | 1 | An iterative operation is in flight; a new start is refused |
| done | output | 1 | One-cycle pulse: `result` is valid |
| result | output | 32 | Selected product word |

## Verification
The bench runs three instances side by side, one for each datapath width. Each is compared on every cycle against a queue-based model, using boundary operands 0, 1, all-ones, the most negative value and the most positive value with every opcode.

A burst of starts on consecutive cycles checks the refusal rule. An iterative unit that restarted or took a second operand would move its `done` pulse or return a different word. The full-width unit would drop or reorder results if its pipeline lost an entry.

Random gaps between starts include a start on the cycle right after `done`. A controller that stretched `busy` by one cycle would refuse that start. The high-word opcodes catch a sign extension applied to the wrong operand, which shows up as a wrong upper word only for negative operands.

// File: rtl/mul_unit_pkg.sv
package mul_unit_pkg;

    localparam int XLEN     = 32;
    localparam int PIPE_LAT = 2;

    typedef enum logic [1:0] {
        MOP_LO    = 2'b00,
        MOP_HI_SS = 2'b01,
        MOP_HI_SU = 2'b10,
        MOP_HI_UU = 2'b11
    } mul_op_e;

    typedef struct packed {
        mul_op_e         op;
        logic [XLEN-1:0] a;
        logic [XLEN-1:0] b;
    } mul_req_t;

    typedef struct packed {
        mul_op_e           op;
        logic [2*XLEN-1:0] prod;
    } mul_prod_t;

    function automatic int digit_count(input int dw);
        return XLEN / dw;
    endfunction

    function automatic int issue_cycles(input int dw);
        return (dw >= XLEN) ? 1 : digit_count(dw) + 3;
    endfunction

    function automatic int total_latency(input int dw);
        return issue_cycles(dw) + PIPE_LAT;
    endfunction

    // Sign treatment of operand A for an opcode
    function automatic logic a_is_signed(input mul_op_e op);
        return (op == MOP_HI_SS) || (op == MOP_HI_SU);
    endfunction

    // Sign treatment of operand B for an opcode
    function automatic logic b_is_signed(input mul_op_e op);
        return (op == MOP_HI_SS);
    endfunction

    function automatic logic [2*XLEN-1:0] widen(input logic [XLEN-1:0] v, input logic sgn);
        return {{XLEN{sgn & v[XLEN-1]}}, v};
    endfunction

    function automatic logic [XLEN-1:0] pick_word(input mul_op_e op, input logic [2*XLEN-1:0] p);
        return (op == MOP_LO) ? p[XLEN-1:0] : p[2*XLEN-1:XLEN];
    endfunction

endpackage

// File: rtl/mul_seq_ctrl.sv
module mul_seq_ctrl
    import mul_unit_pkg::*;
#(
    parameter int LAT  = 13,
    parameter int NDIG = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done,
    output logic accept,
    output logic step_en
);
    localparam int SW = $clog2(LAT + 1);
    localparam logic [SW-1:0] LAST_STEP = SW'(LAT);
    localparam logic [SW-1:0] LAST_DIG  = SW'(NDIG);

    logic [SW-1:0] step_q;
    logic          busy_q;

    always_comb begin
        accept  = start && !busy_q;
        done    = busy_q && (step_q == LAST_STEP);
        step_en = busy_q && (step_q <= LAST_DIG);
        busy    = busy_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            step_q <= '0;
        end else if (accept) begin
            busy_q <= 1'b1;
            step_q <= SW'(1);
        end else if (busy_q) begin
            if (done) begin
                busy_q <= 1'b0;
                step_q <= '0;
            end else begin
                step_q <= step_q + SW'(1);
            end
        end
    end

endmodule

// File: rtl/mul_digit_acc.sv
module mul_digit_acc
    import mul_unit_pkg::*;
#(
    parameter int DW = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic            en,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] result
);
    logic [XLEN-1:0] a_sh;
    logic [XLEN-1:0] b_sh;
    logic [XLEN-1:0] acc;
    logic [XLEN-1:0] partial;

    // One row of the XLEN x DW array, truncated to the low word
    always_comb begin
        partial = a_sh * {{(XLEN-DW){1'b0}}, b_sh[DW-1:0]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            a_sh <= '0;
            b_sh <= '0;
            acc  <= '0;
        end else if (load) begin
            a_sh <= a;
            b_sh <= b;
            acc  <= '0;
        end else if (en) begin
            acc  <= acc + partial;
            a_sh <= a_sh << DW;
            b_sh <= b_sh >> DW;
        end
    end

    assign result = acc;

endmodule

// File: rtl/mul_full_pipe.sv
module mul_full_pipe
    import mul_unit_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  mul_req_t        req,
    output logic            done,
    output logic [XLEN-1:0] result
);
    logic      v1, v2, v3;
    mul_req_t  s1;
    mul_prod_t s2, s2_next;
    logic [XLEN-1:0] res_q;

    always_comb begin
        s2_next.op   = s1.op;
        s2_next.prod = widen(s1.a, a_is_signed(s1.op)) * widen(s1.b, b_is_signed(s1.op));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v1    <= 1'b0;
            v2    <= 1'b0;
            v3    <= 1'b0;
            s1    <= '0;
            s2    <= '0;
            res_q <= '0;
        end else begin
            v1 <= start;
            v2 <= v1;
            v3 <= v2;
            if (start) s1 <= req;
            if (v1)    s2 <= s2_next;
            if (v2)    res_q <= pick_word(s2.op, s2.prod);
        end
    end

    assign done   = v3;
    assign result = res_q;

endmodule

// File: rtl/mul_unit.sv
module mul_unit
    import mul_unit_pkg::*;
#(
    parameter int DIGIT_W = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [1:0]  op,
    input  logic [31:0] a,
    input  logic [31:0] b,
    output logic        busy,
    output logic        done,
    output logic [31:0] result
);
    localparam int NDIG = digit_count(DIGIT_W);
    localparam int LAT  = total_latency(DIGIT_W);

    generate
        if (DIGIT_W >= XLEN) begin : g_full
            mul_req_t req;
            always_comb begin
                req.op = mul_op_e'(op);
                req.a  = a;
                req.b  = b;
            end
            mul_full_pipe u_pipe (
                .clk    (clk),
                .rst    (rst),
                .start  (start),
                .req    (req),
                .done   (done),
                .result (result)
            );
            assign busy = 1'b0;
        end else begin : g_iter
            logic accept;
            logic step_en;
            logic unused_op;
            assign unused_op = ^op;

            mul_seq_ctrl #(
                .LAT  (LAT),
                .NDIG (NDIG)
            ) u_ctrl (
                .clk     (clk),
                .rst     (rst),
                .start   (start),
                .busy    (busy),
                .done    (done),
                .accept  (accept),
                .step_en (step_en)
            );

            mul_digit_acc #(
                .DW (DIGIT_W)
            ) u_acc (
                .clk    (clk),
                .rst    (rst),
                .load   (accept),
                .en     (step_en),
                .a      (a),
                .b      (b),
                .result (result)
            );
        end
    endgenerate

endmodule

// File: rtl/mul_unit_chk.sv
module mul_unit_chk
    import mul_unit_pkg::*;
#(
    parameter int DIGIT_W = 4
) (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        busy,
    input logic        done,
    input logic [31:0] result
);
    localparam bit ITER = (DIGIT_W < XLEN);
    localparam int LAT  = total_latency(DIGIT_W);

    logic [7:0] lat_cnt;
    logic [2:0] st_hist;

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_cnt <= '0;
            st_hist <= '0;
        end else begin
            st_hist <= {st_hist[1:0], start};
            if (start && !busy)
                lat_cnt <= 8'd1;
            else if (lat_cnt != 0 && lat_cnt < 8'(LAT))
                lat_cnt <= lat_cnt + 8'd1;
            else
                lat_cnt <= '0;
        end
    end

    AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (!busy && !done && result == '0)); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) (ITER && done) |=> !done); // R7
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst) (ITER && busy && !done) |=> busy); // R7
    AST_START_BUSY: assert property (@(posedge clk) disable iff (rst) (ITER && start && !busy) |=> busy); // R7
    AST_ITER_LATENCY: assert property (@(posedge clk) disable iff (rst) (ITER && done) |-> (lat_cnt == 8'(LAT))); // R6
    AST_ITER_HOLD: assert property (@(posedge clk) disable iff (rst) (ITER && !busy && !start) |=> $stable(result)); // R11
    AST_FULL_NO_BUSY: assert property (@(posedge clk) disable iff (rst) !ITER |-> !busy); // R9
    AST_FULL_PIPE: assert property (@(posedge clk) disable iff (rst) !ITER |-> (done == st_hist[2])); // R9
    AST_FULL_HOLD: assert property (@(posedge clk) disable iff (rst) (!ITER && !$stable(result)) |-> done); // R11

endmodule

bind mul_unit mul_unit_chk #(.DIGIT_W(DIGIT_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .result (result)
);

// File: tb/mul_unit_tb.sv
module mul_unit_sb #(
    parameter int    DIGIT_W = 4,
    parameter string NAME    = "dut"
) (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic [1:0]  op,
    input logic [31:0] a,
    input logic [31:0] b,
    input logic        busy,
    input logic        done,
    input logic [31:0] result
);
    localparam bit ITER = (DIGIT_W != 32);
    localparam int LAT  = ITER ? (32 / DIGIT_W + 5) : 3;

    typedef struct {
        int          due;
        logic [31:0] val;
        string       tag;
    } exp_t;

    exp_t        q[$];
    int          checks = 0;
    int          fails  = 0;
    int          cyc    = 0;
    int          busy_from  = 0;
    int          busy_until = -1;
    logic [31:0] last_val   = '0;

    function automatic logic [31:0] ref_mul(input logic [1:0] o, input logic [31:0] x, input logic [31:0] y);
        logic [63:0] xa, xb, p;
        if (ITER || o == 2'b00) begin
            p = {32'h0, x} * {32'h0, y};
            return p[31:0];
        end
        xa = (o != 2'b11 && x[31]) ? {32'hFFFF_FFFF, x} : {32'h0, x};
        xb = (o == 2'b01 && y[31]) ? {32'hFFFF_FFFF, y} : {32'h0, y};
        p  = xa * xb;
        return p[63:32];
    endfunction

    function automatic string tag_of(input logic [1:0] o);
        if (ITER) return (o == 2'b00) ? "R1" : "R5";
        case (o)
            2'b00:   return "R1";
            2'b01:   return "R2";
            2'b10:   return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h at cycle %0d", NAME, tag, act, exp, cyc);
        end
    endtask

    // Acceptance model: sampled at the same edge the unit samples start (R8)
    always @(posedge clk) begin
        if (rst) begin
            q.delete();
            busy_from  = 0;
            busy_until = -1;
            last_val   = '0;
        end else if (start && !(ITER && cyc >= busy_from && cyc <= busy_until)) begin
            q.push_back('{due: cyc + LAT, val: ref_mul(op, a, b), tag: tag_of(op)});
            if (ITER) begin
                busy_from  = cyc + 1;
                busy_until = cyc + LAT;
            end
        end
        cyc++;
    end

    always @(negedge clk) begin
        bit exp_done, exp_busy;
        if (rst) begin
            chk(busy == 1'b0, "R10", 32'(busy), 32'h0);
            chk(done == 1'b0, "R10", 32'(done), 32'h0);
            chk(result == 32'h0, "R10", result, 32'h0);
        end else begin
            exp_done = (q.size() > 0) && (q[0].due == cyc);
            exp_busy = ITER && cyc >= busy_from && cyc <= busy_until;
            chk(done == exp_done, "R6/R8", 32'(done), 32'(exp_done));
            chk(busy == exp_busy, ITER ? "R7" : "R9", 32'(busy), 32'(exp_busy));
            if (exp_done) begin
                chk(result == q[0].val, q[0].tag, result, q[0].val);
                last_val = q[0].val;
                void'(q.pop_front());
            end else if (!exp_busy) begin
                chk(result == last_val, "R11", result, last_val);
            end
            while (q.size() > 0 && q[0].due < cyc) void'(q.pop_front());
        end
    end

    task automatic final_check();
        chk(q.size() == 0, "R6", 32'(q.size()), 32'h0);
    endtask

endmodule

module mul_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [31:0] a = '0;
    logic [31:0] b = '0;

    logic        busy_n, done_n, busy_h, done_h, busy_f, done_f;
    logic [31:0] res_n, res_h, res_f;

    int  tb_checks = 0;
    int  tb_fails  = 0;
    bit  finished  = 1'b0;

    always #2 clk = ~clk;

    mul_unit #(.DIGIT_W(4)) u_dut (
        .clk(clk), .rst(rst), .start(start), .op(op), .a(a), .b(b),
        .busy(busy_n), .done(done_n), .result(res_n)
    );
    mul_unit #(.DIGIT_W(16)) u_dut_half (
        .clk(clk), .rst(rst), .start(start), .op(op), .a(a), .b(b),
        .busy(busy_h), .done(done_h), .result(res_h)
    );
    mul_unit #(.DIGIT_W(32)) u_dut_full (
        .clk(clk), .rst(rst), .start(start), .op(op), .a(a), .b(b),
        .busy(busy_f), .done(done_f), .result(res_f)
    );

    mul_unit_sb #(.DIGIT_W(4), .NAME("narrow")) sb_n (
        .clk(clk), .rst(rst), .start(start), .op(op), .a(a), .b(b),
        .busy(busy_n), .done(done_n), .result(res_n)
    );
    mul_unit_sb #(.DIGIT_W(16), .NAME("half")) sb_h (
        .clk(clk), .rst(rst), .start(start), .op(op), .a(a), .b(b),
        .busy(busy_h), .done(done_h), .result(res_h)
    );
    mul_unit_sb #(.DIGIT_W(32), .NAME("full")) sb_f (
        .clk(clk), .rst(rst), .start(start), .op(op), .a(a), .b(b),
        .busy(busy_f), .done(done_f), .result(res_f)
    );

    task automatic issue(input logic [1:0] o, input logic [31:0] x, input logic [31:0] y);
        @(negedge clk);
        start = 1'b1; op = o; a = x; b = y;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d",
                 tb_checks + sb_n.checks + sb_h.checks + sb_f.checks,
                 tb_fails + sb_n.fails + sb_h.fails + sb_f.fails);
    endtask

    initial begin
        logic [31:0] cv [6];
        cv = '{32'h0000_0000, 32'h0000_0001, 32'hFFFF_FFFF,
               32'h8000_0000, 32'h7FFF_FFFF, 32'hDEAD_BEEF};

        // R10: reset state is checked by the scoreboards while rst is high
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1-style corners for every opcode: R1, R2, R3, R4, R5
        for (int i = 0; i < 6; i++)
            for (int j = 0; j < 6; j++)
                for (int k = 0; k < 4; k++) begin
                    issue(2'(k), cv[i], cv[j]);
                    repeat (13) @(negedge clk);
                end

        // R8 and R9: a start on every cycle; iterative units refuse most of them
        for (int n = 0; n < 3; n++) begin
            for (int i = 0; i < 30; i++) begin
                @(negedge clk);
                start = 1'b1;
                op = 2'($urandom);
                a  = $urandom;
                b  = $urandom;
            end
            @(negedge clk);
            start = 1'b0;
            repeat (16) @(negedge clk);
        end

        // R6, R7, R11: random gaps, including a start right after done
        for (int i = 0; i < 400; i++) begin
            issue(2'($urandom), $urandom, $urandom);
            repeat ($urandom_range(0, 15)) @(negedge clk);
        end

        repeat (20) @(negedge clk);
        sb_n.final_check();
        sb_h.final_check();
        sb_f.final_check();

        finished = 1'b1;
        report();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            tb_checks++;
            tb_fails++;
            $display("FAIL watchdog R6: got %0d expected %0d", 0, 1);
            report();
            $finish;
        end
    end

endmodule